// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor that passes procedure arguments through overlapping register windows. Software always sees 32 architectural registers. Indices 0 to 7 are globals that every procedure shares. Indices 8 to 31 are a 24-register view into a larger physical stack, and a current-window pointer (CWP) selects where that view sits. Within each view, eight registers are outgoing parameters, eight are private locals and eight are incoming parameters. The incoming group of one window is the same storage as the outgoing group of the window above it. As a result, a call needs no copying: the caller's outgoing values appear as the callee's incoming values once the pointer moves.

The block has two combinational read ports and one synchronous write port. A window move is requested by pulsing `save_req` when entering a procedure or `restore_req` when leaving one. Each window has one bit in an invalid-window mask, loaded through its own port. A move whose target window is flagged does not take place; instead it raises a one-cycle overflow or underflow flag, which surrounding logic can turn into a spill or fill. The number of implemented windows is a parameter.

Top module: `winreg_file`

## Requirements
- R1: Architectural index 0 always reads as zero on both read ports, and a write to index 0 changes no register.
- R2: Indices 1 to 7 name eight global registers whose contents do not depend on the CWP.
- R3: Index i in 8..31 reaches physical windowed entry (CWP×16 + i − 8) mod (NWIN×16). Indices 8–15 are outs, 16–23 are locals and 24–31 are ins.
- R4: The ins of window w are the same storage as the outs of window (w+1) mod NWIN. After a save, the caller's outs therefore read back as the callee's ins.
- R5: An accepted save sets the CWP to (CWP − 1) mod NWIN on the next clock edge, so a save from window 0 lands on window NWIN−1.
- R6: An accepted restore sets the CWP to (CWP + 1) mod NWIN on the next clock edge, so a restore from window NWIN−1 lands on window 0.
- R7: A save whose target window has its bit set in the invalid-window mask (bit n stands for window n) leaves the CWP unchanged. It drives `ovf_o` high for exactly the following cycle.
- R8: A restore whose target window is marked invalid leaves the CWP unchanged. It drives `unf_o` high for exactly the following cycle.
- R9: When save and restore are requested in the same cycle, the save is carried out and the restore is ignored.
- R10: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R11: A write issued in the same cycle as a save or restore is placed through the CWP in force before the move.
- R12: After reset the CWP is 0, both flags are low, the invalid-window mask is all zeros and every register reads zero.
- R13: `mask_wr_en` loads `mask_in` into the invalid-window mask at the clock edge. A save or restore in that same cycle is judged against the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | XLEN | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Request to move to the next-lower window |
| restore_req | input | 1 | Request to move to the next-higher window |
| mask_wr_en | input | 1 | Load the invalid-window mask |
| mask_in | input | NWIN | New invalid-window mask, one bit per window |
| cwp_o | output | 5 | Current window pointer |
| ovf_o | output | 1 | Save refused because of the mask |
| unf_o | output | 1 | Restore refused because of the mask |

## Verification
The bench builds the file with NWIN = 5, which is not a power of two. This exercises the modulo wrap of both the pointer and the physical address on a stack whose depth of 80 entries is not a binary boundary, and a short run goes round it several times. XLEN stays at 32. With five windows, a few directed saves and restores reach both wrap points, the out/in alias between neighbouring windows, and masked targets on either side of the current window. Random traffic then mixes moves, writes and mask loads against a reference model.

// File: rtl/winreg_pkg.sv
// Package winreg_pkg
// Shared constants and types for the windowed register file.
// Assumes a 32-entry architectural index space and 16 physical entries
// added per implemented window (8 locals + 8 shared outs/ins).
package winreg_pkg;

    localparam int IDX_W      = 5;   // architectural index width
    localparam int CWP_W      = 5;   // window pointer width
    localparam int NGLOB      = 8;   // globals, index 0 reads zero
    localparam int WIN_STRIDE = 16;  // physical entries between windows
    localparam int WIN_BASE   = 8;   // first windowed architectural index

    typedef logic [IDX_W-1:0] arch_idx_t;
    typedef logic [CWP_W-1:0] cwp_t;

    // Requested window move after priority resolution
    typedef enum logic [1:0] {
        MV_NONE    = 2'd0,
        MV_SAVE    = 2'd1,
        MV_RESTORE = 2'd2
    } move_t;

endpackage

// File: rtl/winreg_map.sv
// Module winreg_map
// Translates one architectural index into either a global slot or a
// physical windowed entry under the given window pointer.
// Assumes cwp < NWIN; the sum then stays below twice the stack depth,
// so a single conditional subtraction performs the modulo.
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int DEPTH = NWIN * WIN_STRIDE,
    localparam int PW    = $clog2(DEPTH),
    localparam int SW    = PW + 1
) (
    input  cwp_t          cwp,
    input  arch_idx_t     idx,
    output logic          is_glob,
    output logic [2:0]    gsel,
    output logic [PW-1:0] wsel
);

    logic [SW-1:0] base;
    logic [SW-1:0] offs;
    logic [SW-1:0] sum;

    // Form the unwrapped physical position and fold it once
    always_comb begin
        is_glob = (idx < arch_idx_t'(WIN_BASE));
        gsel    = idx[2:0];
        base    = SW'(cwp) << 4;
        offs    = SW'(idx) - SW'(WIN_BASE);
        sum     = base + offs;
        if (sum >= SW'(DEPTH)) begin
            wsel = PW'(sum - SW'(DEPTH));
        end else begin
            wsel = PW'(sum);
        end
    end

endmodule

// File: rtl/winreg_ptr.sv
// Module winreg_ptr
// Holds the current window pointer and the invalid-window mask, resolves
// save/restore requests (save wins) and raises one-cycle refusal flags.
// Assumes 3 <= NWIN <= 32. The mask load and a move in the same cycle
// see the mask value held before that edge.
module winreg_ptr
    import winreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            mask_wr_en,
    input  logic [NWIN-1:0] mask_in,
    output cwp_t            cwp,
    output logic            ovf,
    output logic            unf
);

    localparam cwp_t            LAST = cwp_t'(NWIN - 1);
    localparam logic [NWIN-1:0] ONE  = NWIN'(1);

    cwp_t            cwp_q;
    logic [NWIN-1:0] mask_q;
    move_t           mv;
    cwp_t            tgt_dn;
    cwp_t            tgt_up;
    logic            blk_dn;
    logic            blk_up;

    // Pick the move and the neighbouring windows with wrap-around
    always_comb begin
        if (save_req) begin
            mv = MV_SAVE;
        end else if (restore_req) begin
            mv = MV_RESTORE;
        end else begin
            mv = MV_NONE;
        end
        tgt_dn = (cwp_q == '0)   ? LAST : cwp_q - 1'b1;
        tgt_up = (cwp_q == LAST) ? '0   : cwp_q + 1'b1;
        blk_dn = |(mask_q & (ONE << tgt_dn));
        blk_up = |(mask_q & (ONE << tgt_up));
    end

    // Update pointer, mask and refusal flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            mask_q <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            ovf <= (mv == MV_SAVE)    && blk_dn;
            unf <= (mv == MV_RESTORE) && blk_up;
            case (mv)
                MV_SAVE:    if (!blk_dn) cwp_q <= tgt_dn;
                MV_RESTORE: if (!blk_up) cwp_q <= tgt_up;
                default:    cwp_q <= cwp_q;
            endcase
            if (mask_wr_en) begin
                mask_q <= mask_in;
            end
        end
    end

    assign cwp = cwp_q;

endmodule

// File: rtl/winreg_store.sv
// Module winreg_store
// Storage for the globals and the windowed stack, with NRD decoded read
// ports and one decoded write port. Global slot 0 is never written and
// always reads zero. Reads are combinational and see pre-edge contents.
// Assumes addresses arrive already translated by winreg_map.
module winreg_store
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int NRD  = 2,
    localparam int DEPTH = NWIN * WIN_STRIDE,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_glob [NRD],
    input  logic [2:0]      rd_gsel [NRD],
    input  logic [PW-1:0]   rd_wsel [NRD],
    output logic [XLEN-1:0] rd_data [NRD],
    input  logic            wr_en,
    input  logic            wr_glob,
    input  logic [2:0]      wr_gsel,
    input  logic [PW-1:0]   wr_wsel,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] glob_q [NGLOB];
    logic [XLEN-1:0] win_q  [DEPTH];

    // Clear everything on reset, then apply the single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NGLOB; g++) begin
                glob_q[g] <= '0;
            end
            for (int e = 0; e < DEPTH; e++) begin
                win_q[e] <= '0;
            end
        end else if (wr_en) begin
            if (wr_glob) begin
                if (wr_gsel != 3'd0) begin
                    glob_q[wr_gsel] <= wr_data;
                end
            end else begin
                win_q[wr_wsel] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Select the addressed entry for read port p
        always_comb begin
            if (rd_glob[p]) begin
                rd_data[p] = (rd_gsel[p] == 3'd0) ? '0 : glob_q[rd_gsel[p]];
            end else begin
                rd_data[p] = win_q[rd_wsel[p]];
            end
        end
    end

endmodule

// File: rtl/winreg_file.sv
// Module winreg_file
// Top of the windowed integer register file: 8 globals plus a 24-entry
// sliding view into NWIN overlapping windows, two read ports, one write
// port, and save/restore control of the window pointer.
// Assumes 3 <= NWIN <= 32; reset is synchronous and active low.
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int DEPTH = NWIN * WIN_STRIDE,
    localparam int PW    = $clog2(DEPTH),
    localparam int NRD   = 2,
    localparam int NPORT = NRD + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            mask_wr_en,
    input  logic [NWIN-1:0] mask_in,
    output logic [4:0]      cwp_o,
    output logic            ovf_o,
    output logic            unf_o
);

    cwp_t            cwp;
    arch_idx_t       p_idx  [NPORT];
    logic            p_glob [NPORT];
    logic [2:0]      p_gsel [NPORT];
    logic [PW-1:0]   p_wsel [NPORT];
    logic            r_glob [NRD];
    logic [2:0]      r_gsel [NRD];
    logic [PW-1:0]   r_wsel [NRD];
    logic [XLEN-1:0] r_data [NRD];

    // Gather port indices: read ports first, write port last
    always_comb begin
        p_idx[0] = rd_a_idx;
        p_idx[1] = rd_b_idx;
        p_idx[2] = wr_idx;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        winreg_map #(.NWIN(NWIN)) i_map (
            .cwp     (cwp),
            .idx     (p_idx[p]),
            .is_glob (p_glob[p]),
            .gsel    (p_gsel[p]),
            .wsel    (p_wsel[p])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rdsel
        // Hand read-port translations to the storage
        always_comb begin
            r_glob[r] = p_glob[r];
            r_gsel[r] = p_gsel[r];
            r_wsel[r] = p_wsel[r];
        end
    end

    winreg_ptr #(.NWIN(NWIN)) i_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_wr_en  (mask_wr_en),
        .mask_in     (mask_in),
        .cwp         (cwp),
        .ovf         (ovf_o),
        .unf         (unf_o)
    );

    winreg_store #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_glob (r_glob),
        .rd_gsel (r_gsel),
        .rd_wsel (r_wsel),
        .rd_data (r_data),
        .wr_en   (wr_en),
        .wr_glob (p_glob[NRD]),
        .wr_gsel (p_gsel[NRD]),
        .wr_wsel (p_wsel[NRD]),
        .wr_data (wr_data)
    );

    assign rd_a_data = r_data[0];
    assign rd_b_data = r_data[1];
    assign cwp_o     = cwp;

endmodule

// File: rtl/winreg_file_chk.sv
// Module winreg_file_chk
// Port-level temporal checks for winreg_file, bound to every instance.
module winreg_file_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic [4:0]      rd_b_idx,
    input logic [XLEN-1:0] rd_b_data,
    input logic            save_req,
    input logic            restore_req,
    input logic [4:0]      cwp_o,
    input logic            ovf_o,
    input logic            unf_o
);

    function automatic logic [4:0] dn(input logic [4:0] w);
        return (w == 5'd0) ? 5'(NWIN - 1) : w - 5'd1;
    endfunction

    function automatic logic [4:0] up(input logic [4:0] w);
        return (w == 5'(NWIN - 1)) ? 5'd0 : w + 5'd1;
    endfunction

    // R1
    zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    // R1
    zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

    // R5
    save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> (ovf_o || (cwp_o == dn($past(cwp_o)))));

    // R6
    restore_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req) |=> (unf_o || (cwp_o == up($past(cwp_o)))));

    // R5
    cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_o < 5'(NWIN));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> (!ovf_o || (cwp_o == $past(cwp_o))));

    // R8
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req) |=> (!unf_o || (cwp_o == $past(cwp_o))));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    // R9
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> !unf_o);

endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .XLEN(XLEN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .cwp_o       (cwp_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/test_winreg_file.sv
module test_winreg_file;

    localparam int NW = 5;
    localparam int XL = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic [XL-1:0] rd_a_data, rd_b_data, wr_data;
    logic          wr_en, save_req, restore_req, mask_wr_en;
    logic [NW-1:0] mask_in;
    logic [4:0]    cwp_o;
    logic          ovf_o, unf_o;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [XL-1:0] m_glob [8];
    logic [XL-1:0] m_win  [NW*16];
    int            m_cwp;
    logic [NW-1:0] m_mask;
    logic          m_ovf, m_unf;

    always #2 clk = ~clk;

    winreg_file #(.NWIN(NW), .XLEN(XL)) i_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .mask_wr_en(mask_wr_en), .mask_in(mask_in),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic int phys_of(int w, int idx);
        return (w * 16 + idx - 8) % (NW * 16);
    endfunction

    function automatic logic [XL-1:0] ref_read(int idx);
        if (idx == 0) return '0;
        if (idx < 8)  return m_glob[idx];
        return m_win[phys_of(m_cwp, idx)];
    endfunction

    task automatic check(input logic [XL-1:0] act, input logic [XL-1:0] exp,
                         input string what, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int g = 0; g < 8; g++) m_glob[g] = '0;
        for (int e = 0; e < NW*16; e++) m_win[e] = '0;
        m_cwp = 0; m_mask = '0; m_ovf = 1'b0; m_unf = 1'b0;
    endtask

    // One cycle: drive at negedge, compare before the edge, update model at the edge
    task automatic step(input logic [4:0] ra, input logic [4:0] rb,
                        input logic we, input logic [4:0] wi, input logic [XL-1:0] wd,
                        input logic sv, input logic rs,
                        input logic mw, input logic [NW-1:0] mv, input string tag);
        int dn, up;
        @(negedge clk);
        rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
        save_req = sv; restore_req = rs; mask_wr_en = mw; mask_in = mv;
        #1;
        check(rd_a_data, ref_read(ra), "read A", tag);
        check(rd_b_data, ref_read(rb), "read B", tag);
        check(XL'(cwp_o), XL'(m_cwp), "cwp", tag);
        check(XL'(ovf_o), XL'(m_ovf), "ovf", tag);
        check(XL'(unf_o), XL'(m_unf), "unf", tag);
        @(posedge clk);
        if (we && wi != 0) begin
            if (wi < 8) m_glob[wi] = wd;
            else        m_win[phys_of(m_cwp, wi)] = wd;
        end
        dn = (m_cwp + NW - 1) % NW;
        up = (m_cwp + 1) % NW;
        m_ovf = 1'b0; m_unf = 1'b0;
        if (sv) begin
            if (m_mask[dn]) m_ovf = 1'b1;
            else            m_cwp = dn;
        end else if (rs) begin
            if (m_mask[up]) m_unf = 1'b1;
            else            m_cwp = up;
        end
        if (mw) m_mask = mv;
    endtask

    task automatic rd(input logic [4:0] a, input logic [4:0] b, input string tag);
        step(a, b, 1'b0, 5'd0, '0, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic wr(input logic [4:0] i, input logic [XL-1:0] d, input string tag);
        step(i, 5'd0, 1'b1, i, d, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic mv(input logic sv, input logic rs, input string tag);
        step(5'd8, 5'd24, 1'b0, 5'd0, '0, sv, rs, 1'b0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        int cw;
        seed = $urandom(32'd7321);
        rst_n = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        save_req = 1'b0; restore_req = 1'b0; mask_wr_en = 1'b0; mask_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: every index reads zero, pointer 0, flags low
        for (int i = 0; i < 32; i += 2) rd(5'(i), 5'(i + 1), "R12");

        // R1: writes to index 0 are discarded
        wr(5'd0, 32'hDEAD_BEEF, "R1");
        rd(5'd0, 5'd0, "R1");

        // R2: globals survive window moves
        wr(5'd3, 32'h1111_0003, "R2");
        wr(5'd7, 32'h1111_0007, "R2");
        mv(1'b1, 1'b0, "R2");
        rd(5'd3, 5'd7, "R2");
        mv(1'b0, 1'b1, "R2");

        // R3: outs, locals, ins in window 0
        wr(5'd9,  32'hA000_0009, "R3");
        wr(5'd17, 32'hA000_0017, "R3");
        wr(5'd25, 32'hA000_0025, "R3");
        rd(5'd9, 5'd17, "R3");
        rd(5'd25, 5'd31, "R3");

        // R4: caller outs become callee ins after a save
        wr(5'd10, 32'hB0B0_0010, "R4");
        mv(1'b1, 1'b0, "R4");
        rd(5'd26, 5'd10, "R4");
        mv(1'b0, 1'b1, "R4");

        // R5: save wrap from window 0 and full lap downward
        for (int k = 0; k < NW + 1; k++) mv(1'b1, 1'b0, "R5");
        // R6: restore laps back across the top
        for (int k = 0; k < NW + 1; k++) mv(1'b0, 1'b1, "R6");
        rd(5'd0, 5'd0, "R6");

        // R10: same-cycle read of the written register sees old data
        step(5'd17, 5'd17, 1'b1, 5'd17, 32'hC0DE_0017, 1'b0, 1'b0, 1'b0, '0, "R10");
        rd(5'd17, 5'd17, "R10");

        // R11: write with a save lands in the pre-move window
        step(5'd12, 5'd28, 1'b1, 5'd12, 32'hEE11_0012, 1'b1, 1'b0, 1'b0, '0, "R11");
        rd(5'd28, 5'd12, "R11");
        step(5'd20, 5'd12, 1'b1, 5'd20, 32'hEE11_0020, 1'b0, 1'b1, 1'b0, '0, "R11");
        rd(5'd12, 5'd20, "R11");

        // R9: save and restore together act as a save
        mv(1'b1, 1'b1, "R9");
        mv(1'b0, 1'b0, "R9");
        mv(1'b0, 1'b1, "R9");

        // R13: mask load with save uses the old mask
        cw = m_cwp;
        step(5'd8, 5'd9, 1'b0, 5'd0, '0, 1'b1, 1'b0, 1'b1,
             NW'(1) << ((cw + NW - 2) % NW), "R13");
        // R7: the window below is now masked
        mv(1'b1, 1'b0, "R7");
        mv(1'b0, 1'b0, "R7");
        mv(1'b1, 1'b0, "R7");
        // R8: mask the window above and try a restore
        step(5'd8, 5'd9, 1'b0, 5'd0, '0, 1'b0, 1'b0, 1'b1,
             NW'(1) << ((m_cwp + 1) % NW), "R8");
        mv(1'b0, 1'b1, "R8");
        mv(1'b0, 1'b0, "R8");
        step(5'd8, 5'd9, 1'b0, 5'd0, '0, 1'b0, 1'b0, 1'b1, '0, "R13");

        // Random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ra, rb, wi;
            logic we, sv, rs, mw;
            logic [NW-1:0] mk;
            ra = 5'($urandom); rb = 5'($urandom); wi = 5'($urandom);
            we = ($urandom % 2) == 0;
            sv = ($urandom % 5) == 0;
            rs = ($urandom % 5) == 0;
            mw = ($urandom % 25) == 0;
            mk = NW'($urandom & $urandom & $urandom);
            step(ra, rb, we, wi, $urandom, sv, rs, mw, mk, "R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule